// File: doc/BRIEF.md
# USB Controller Power-Up Sequencer

This block is a hardware state machine that takes a dual-role USB controller from reset to a running host-mode state. A single start pulse launches a fixed series of control-word writes. The machine asserts the resets and selects a controller-clock divider. It checks that divider setting against a readback from the register. It then programs the reference-clock constants and powers the PHYs. Finally it releases the resets one at a time, with timed gaps between them.

The frequency of the input clock is given in MHz. From it the sequencer picks the smallest divider ratio that puts the controller clock between 150 MHz and 300 MHz. A rate code and a source select set the PLL multiplier and the frequency-select constant. The configuration inputs are captured when start is accepted. The sequence ends with either a done flag or an error flag, and the flag stays set until the next start.

Top module: `usb_pwrup_seq`

## Requirements
- R1: After reset every control output is 0, except role_dev_o, which is 1 (device). done_o and err_o are both 0.
- R2: The edge that accepts start_i clears done_o and err_o and captures the configuration inputs. The next edge asserts phy_rst_o, hc_rst_o and ctl_rst_o together. The edge after that asserts div_rst_o.
- R3: The edge after the divider reset drives hclk_en_o to 1 and drives div_sel_o to the lowest code k in 0..7 for which 150*r(k) <= in_mhz_i <= 300*r(k). The ratios r(0..7) are 1, 2, 4, 6, 8, 16, 24 and 32. If no code qualifies, the code is 7.
- R4: One cycle after that write, the readback is compared. If div_sel_rb_i differs from div_sel_o, or div_en_rb_i is 0, then err_o rises and div_rst_o stays at 1. The sequence stops, and every output holds until the next start.
- R5: div_rst_o returns to 0 only on the edge where the readback comparison passes.
- R6: mult_o is 0x19 for rate code 0 (100 MHz), 0x32 for code 1 (50 MHz) and 0x28 for code 2 (125 MHz). Code 3 is treated as 100 MHz.
- R7: fsel_o is 0x27 when the rate is treated as 100 MHz and the source select is below 2. Otherwise it is 0x07. fsel_o is written on the edge after the readback passes. The same write sets ref_src_o to the captured source select and sets mult_o, ssc_en_o, ssp_ref_en_o, hs_pwr_o and ss_pwr_o.
- R8: ctl_rst_o falls 10 cycles after that write. hc_rst_o falls 10 cycles after that. Another 10 cycles later, if_clk_en_o rises and role_dev_o goes to 0 (host).
- R9: One cycle after host mode is selected, phy_rst_o falls and done_o rises. done_o and err_o are never 1 together, and each holds until the next accepted start.
- R10: A start pulse that arrives while a sequence is running is ignored. Configuration inputs that change during a sequence have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| rate_code_i | input | 2 | Reference-clock rate code |
| src_sel_i | input | 2 | Reference-clock source select |
| in_mhz_i | input | MHZ_W | Input clock frequency in MHz |
| div_sel_rb_i | input | 3 | Readback of the divider select |
| div_en_rb_i | input | 1 | Readback of the controller clock enable |
| phy_rst_o | output | 1 | PHY reset |
| hc_rst_o | output | 1 | Host-controller reset |
| ctl_rst_o | output | 1 | Control-logic reset |
| div_rst_o | output | 1 | Divider reset |
| div_sel_o | output | 3 | Divider select code |
| hclk_en_o | output | 1 | Controller clock enable |
| ref_src_o | output | 2 | Reference-clock source select |
| fsel_o | output | 6 | Reference frequency select |
| mult_o | output | 7 | PLL multiplier |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| ssp_ref_en_o | output | 1 | SuperSpeed reference enable |
| hs_pwr_o | output | 1 | High-speed PHY power |
| ss_pwr_o | output | 1 | SuperSpeed PHY power |
| if_clk_en_o | output | 1 | Interface clock enable |
| role_dev_o | output | 1 | Role: 1 device, 0 host |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Divider readback failed |

## Verification
The assertions assume the readback inputs describe the register state seen by the sequencer. They also assume start_i is a pulse sampled on the clock. The bench meets the first assumption by looping div_sel_o and hclk_en_o back to the readback pins. A fault mask sits in that loop, and it is altered only in the error tests. The bench drives start and the configuration inputs on falling edges. It keeps in_mhz_i within MHZ_W bits.

// File: rtl/usb_pwrup_pkg.sv
package usb_pwrup_pkg;

    localparam int DIV_W  = 3;
    localparam int SRC_W  = 2;
    localparam int RATE_W = 2;
    localparam int FSEL_W = 6;
    localparam int MULT_W = 7;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RST, ST_DIVRST, ST_DIVSEL, ST_CHECK,
        ST_REFCFG, ST_W_CTL, ST_W_HC, ST_W_IF, ST_FIN
    } seq_st_e;

    typedef struct packed {
        logic              phy_rst;
        logic              hc_rst;
        logic              ctl_rst;
        logic              div_rst;
        logic [DIV_W-1:0]  div_sel;
        logic              hclk_en;
        logic [SRC_W-1:0]  ref_src;
        logic [FSEL_W-1:0] fsel;
        logic [MULT_W-1:0] mult;
        logic              ssc_en;
        logic              ssp_en;
        logic              hs_pwr;
        logic              ss_pwr;
        logic              if_clk_en;
        logic              role_dev;
    } ctl_word_t;

endpackage

// File: rtl/usb_div_pick.sv
module usb_div_pick #(
    parameter int MHZ_W  = 14,
    parameter int LO_MHZ = 150,
    parameter int HI_MHZ = 300
) (
    input  logic [MHZ_W-1:0]                mhz_i,
    output logic [usb_pwrup_pkg::DIV_W-1:0] sel_o
);
    localparam int NDIV = 1 << usb_pwrup_pkg::DIV_W;

    function automatic int ratio_f(input int k);
        case (k)
            0: ratio_f = 1;
            1: ratio_f = 2;
            2: ratio_f = 4;
            3: ratio_f = 6;
            4: ratio_f = 8;
            5: ratio_f = 16;
            6: ratio_f = 24;
            default: ratio_f = 32;
        endcase
    endfunction

    logic [31:0]     mhz_ext;
    logic [NDIV-1:0] hit;

    assign mhz_ext = 32'(mhz_i);

    for (genvar g = 0; g < NDIV; g++) begin : g_win
        localparam logic [31:0] LO = 32'(LO_MHZ * ratio_f(g));
        localparam logic [31:0] HI = 32'(HI_MHZ * ratio_f(g));
        assign hit[g] = (mhz_ext >= LO) && (mhz_ext <= HI);
    end

    always_comb begin
        sel_o = usb_pwrup_pkg::DIV_W'(NDIV - 1);
        for (int k = NDIV - 1; k >= 0; k--) begin
            if (hit[k]) sel_o = usb_pwrup_pkg::DIV_W'(k);
        end
    end

    always_comb begin
        if (hit[sel_o] == 1'b0) begin
            AST_NOHIT_MAX: assert (hit == '0 && sel_o == usb_pwrup_pkg::DIV_W'(NDIV - 1)); // R3
        end
    end
endmodule

// File: rtl/usb_refclk_lut.sv
module usb_refclk_lut (
    input  logic [usb_pwrup_pkg::RATE_W-1:0] rate_i,
    input  logic [usb_pwrup_pkg::SRC_W-1:0]  src_i,
    output logic [usb_pwrup_pkg::MULT_W-1:0] mult_o,
    output logic [usb_pwrup_pkg::FSEL_W-1:0] fsel_o
);
    logic is_100;

    always_comb begin
        is_100 = 1'b0;
        case (rate_i)
            2'd1:    mult_o = 7'h32;
            2'd2:    mult_o = 7'h28;
            default: begin
                mult_o = 7'h19;
                is_100 = 1'b1;
            end
        endcase
        fsel_o = (is_100 && src_i < 2'd2) ? 6'h27 : 6'h07;
    end
endmodule

// File: rtl/usb_wait_timer.sv
module usb_wait_timer #(
    parameter int WAIT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        cnt_d  = (!run_i || tick_o) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R8
endmodule

// File: rtl/usb_pwrup_seq.sv
module usb_pwrup_seq #(
    parameter int MHZ_W    = 14,
    parameter int WAIT_CYC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       rate_code_i,
    input  logic [1:0]       src_sel_i,
    input  logic [MHZ_W-1:0] in_mhz_i,
    input  logic [2:0]       div_sel_rb_i,
    input  logic             div_en_rb_i,
    output logic             phy_rst_o,
    output logic             hc_rst_o,
    output logic             ctl_rst_o,
    output logic             div_rst_o,
    output logic [2:0]       div_sel_o,
    output logic             hclk_en_o,
    output logic [1:0]       ref_src_o,
    output logic [5:0]       fsel_o,
    output logic [6:0]       mult_o,
    output logic             ssc_en_o,
    output logic             ssp_ref_en_o,
    output logic             hs_pwr_o,
    output logic             ss_pwr_o,
    output logic             if_clk_en_o,
    output logic             role_dev_o,
    output logic             done_o,
    output logic             err_o
);
    import usb_pwrup_pkg::*;

    typedef struct packed {
        seq_st_e           st;
        ctl_word_t         ctl;
        logic              done;
        logic              err;
        logic [RATE_W-1:0] rate;
        logic [SRC_W-1:0]  src;
        logic [MHZ_W-1:0]  mhz;
    } seq_t;

    seq_t d, q;

    logic [DIV_W-1:0]  pick_sel;
    logic [MULT_W-1:0] lut_mult;
    logic [FSEL_W-1:0] lut_fsel;
    logic              wait_run;
    logic              wait_tick;

    usb_div_pick #(.MHZ_W(MHZ_W)) u_pick (
        .mhz_i (q.mhz),
        .sel_o (pick_sel)
    );

    usb_refclk_lut u_lut (
        .rate_i (q.rate),
        .src_i  (q.src),
        .mult_o (lut_mult),
        .fsel_o (lut_fsel)
    );

    assign wait_run = (q.st == ST_W_CTL) || (q.st == ST_W_HC) || (q.st == ST_W_IF);

    usb_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (wait_run),
        .tick_o (wait_tick)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: if (start_i) begin
                d.st   = ST_RST;
                d.done = 1'b0;
                d.err  = 1'b0;
                d.rate = rate_code_i;
                d.src  = src_sel_i;
                d.mhz  = in_mhz_i;
            end
            ST_RST: begin
                d.ctl.phy_rst = 1'b1;
                d.ctl.hc_rst  = 1'b1;
                d.ctl.ctl_rst = 1'b1;
                d.st          = ST_DIVRST;
            end
            ST_DIVRST: begin
                d.ctl.div_rst = 1'b1;
                d.st          = ST_DIVSEL;
            end
            ST_DIVSEL: begin
                d.ctl.div_sel = pick_sel;
                d.ctl.hclk_en = 1'b1;
                d.st          = ST_CHECK;
            end
            ST_CHECK: begin
                if ((div_sel_rb_i != q.ctl.div_sel) || !div_en_rb_i) begin
                    d.err = 1'b1;
                    d.st  = ST_IDLE;
                end else begin
                    d.ctl.div_rst = 1'b0;
                    d.st          = ST_REFCFG;
                end
            end
            ST_REFCFG: begin
                d.ctl.ref_src = q.src;
                d.ctl.fsel    = lut_fsel;
                d.ctl.mult    = lut_mult;
                d.ctl.ssc_en  = 1'b1;
                d.ctl.ssp_en  = 1'b1;
                d.ctl.hs_pwr  = 1'b1;
                d.ctl.ss_pwr  = 1'b1;
                d.st          = ST_W_CTL;
            end
            ST_W_CTL: if (wait_tick) begin
                d.ctl.ctl_rst = 1'b0;
                d.st          = ST_W_HC;
            end
            ST_W_HC: if (wait_tick) begin
                d.ctl.hc_rst = 1'b0;
                d.st         = ST_W_IF;
            end
            ST_W_IF: if (wait_tick) begin
                d.ctl.if_clk_en = 1'b1;
                d.ctl.role_dev  = 1'b0;
                d.st            = ST_FIN;
            end
            ST_FIN: begin
                d.ctl.phy_rst = 1'b0;
                d.done        = 1'b1;
                d.st          = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q              <= '0;
            q.st           <= ST_IDLE;
            q.ctl.role_dev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign phy_rst_o    = q.ctl.phy_rst;
    assign hc_rst_o     = q.ctl.hc_rst;
    assign ctl_rst_o    = q.ctl.ctl_rst;
    assign div_rst_o    = q.ctl.div_rst;
    assign div_sel_o    = q.ctl.div_sel;
    assign hclk_en_o    = q.ctl.hclk_en;
    assign ref_src_o    = q.ctl.ref_src;
    assign fsel_o       = q.ctl.fsel;
    assign mult_o       = q.ctl.mult;
    assign ssc_en_o     = q.ctl.ssc_en;
    assign ssp_ref_en_o = q.ctl.ssp_en;
    assign hs_pwr_o     = q.ctl.hs_pwr;
    assign ss_pwr_o     = q.ctl.ss_pwr;
    assign if_clk_en_o  = q.ctl.if_clk_en;
    assign role_dev_o   = q.ctl.role_dev;
    assign done_o       = q.done;
    assign err_o        = q.err;

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.done && q.err)); // R9
    AST_DIVRST_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ctl.div_rst) |-> ($past(q.st) == ST_CHECK) && q.ctl.hclk_en); // R5
    AST_HC_AFTER_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ctl.hc_rst) |-> !q.ctl.ctl_rst && q.ctl.ss_pwr); // R8
    AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> !q.ctl.phy_rst && !q.ctl.role_dev && q.ctl.if_clk_en); // R9
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !start_i) |=> q.err && $stable(q.ctl)); // R4
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.mhz) && $stable(q.rate)); // R10
endmodule

// File: tb/usb_pwrup_seq_bench.sv
module usb_pwrup_seq_bench;
    localparam int MHZ_W = 14;
    localparam int NV    = 12;

    // {in_mhz, rate, src, exp_div, exp_mult, exp_fsel}
    localparam logic [33:0] VEC [NV] = '{
        {14'd600,  2'd0, 2'd0, 3'd1, 7'h19, 6'h27},
        {14'd200,  2'd1, 2'd2, 3'd0, 7'h32, 6'h07},
        {14'd1000, 2'd2, 2'd1, 3'd2, 7'h28, 6'h07},
        {14'd1500, 2'd3, 2'd1, 3'd3, 7'h19, 6'h27},
        {14'd150,  2'd0, 2'd3, 3'd0, 7'h19, 6'h07},
        {14'd300,  2'd0, 2'd2, 3'd0, 7'h19, 6'h07},
        {14'd149,  2'd0, 2'd0, 3'd7, 7'h19, 6'h27},
        {14'd2400, 2'd2, 2'd0, 3'd4, 7'h28, 6'h07},
        {14'd4000, 2'd1, 2'd1, 3'd5, 7'h32, 6'h07},
        {14'd7000, 2'd3, 2'd0, 3'd6, 7'h19, 6'h27},
        {14'd301,  2'd1, 2'd0, 3'd1, 7'h32, 6'h07},
        {14'd8000, 2'd0, 2'd1, 3'd7, 7'h19, 6'h27}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] rate = '0;
    logic [1:0] src = '0;
    logic [MHZ_W-1:0] mhz = '0;
    logic [2:0] sel_flip = '0;
    logic en_kill = 1'b0;

    logic phy_rst, hc_rst, ctl_rst, div_rst, hclk_en, ssc_en, ssp_en;
    logic hs_pwr, ss_pwr, if_clk_en, role_dev, done, err;
    logic [2:0] div_sel;
    logic [1:0] ref_src;
    logic [5:0] fsel;
    logic [6:0] mult;
    logic [2:0] sel_rb;
    logic en_rb;

    int n_chk = 0;
    int n_fail = 0;
    int cur = 0;

    always #4 clk = ~clk;

    assign sel_rb = div_sel ^ sel_flip;
    assign en_rb  = hclk_en & ~en_kill;

    usb_pwrup_seq #(.MHZ_W(MHZ_W)) u_usb_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rate_code_i(rate),
        .src_sel_i(src), .in_mhz_i(mhz), .div_sel_rb_i(sel_rb),
        .div_en_rb_i(en_rb), .phy_rst_o(phy_rst), .hc_rst_o(hc_rst),
        .ctl_rst_o(ctl_rst), .div_rst_o(div_rst), .div_sel_o(div_sel),
        .hclk_en_o(hclk_en), .ref_src_o(ref_src), .fsel_o(fsel),
        .mult_o(mult), .ssc_en_o(ssc_en), .ssp_ref_en_o(ssp_en),
        .hs_pwr_o(hs_pwr), .ss_pwr_o(ss_pwr), .if_clk_en_o(if_clk_en),
        .role_dev_o(role_dev), .done_o(done), .err_o(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // pulse start; returns at the falling edge after the accepting edge (cur = 0)
    task automatic kick(input logic [MHZ_W-1:0] m, input logic [1:0] r, input logic [1:0] s);
        @(negedge clk);
        mhz = m; rate = r; src = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cur = 0;
    endtask

    // advance to the falling edge after rising edge number k since start
    task automatic step(input int k);
        while (cur < k) begin
            @(negedge clk);
            cur++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 resets", {phy_rst, hc_rst, ctl_rst, div_rst}, 4'b0000);
        chk("R1 fields", {div_sel, hclk_en, fsel, mult, ssc_en, if_clk_en}, '0);
        chk("R1 role", role_dev, 1'b1);
        chk("R1 flags", {done, err}, 2'b00);

        // directed timing run
        kick(14'd600, 2'd0, 2'd0);
        chk("R2 flags cleared", {done, err}, 2'b00);
        step(1);
        chk("R2 three resets", {phy_rst, hc_rst, ctl_rst, div_rst}, 4'b1110);
        step(2);
        chk("R2 divider reset", div_rst, 1'b1);
        chk("R3 not yet", hclk_en, 1'b0);
        step(3);
        chk("R3 div sel", div_sel, 3'd1);
        chk("R3 clk en", hclk_en, 1'b1);
        chk("R5 held before check", div_rst, 1'b1);
        step(4);
        chk("R5 released", div_rst, 1'b0);
        chk("R7 not yet", {ssc_en, mult}, '0);
        step(5);
        chk("R6 mult", mult, 7'h19);
        chk("R7 fsel", fsel, 6'h27);
        chk("R7 one write", {ssc_en, ssp_en, hs_pwr, ss_pwr}, 4'b1111);
        chk("R8 ctl still", ctl_rst, 1'b1);
        step(10);
        // R10: start while busy, with changed inputs
        start = 1'b1; rate = 2'd1; mhz = 14'd200;
        @(negedge clk); cur++;
        start = 1'b0;
        step(14);
        chk("R8 ctl before", ctl_rst, 1'b1);
        step(15);
        chk("R8 ctl released", {ctl_rst, hc_rst}, 2'b01);
        step(24);
        chk("R8 hc before", hc_rst, 1'b1);
        step(25);
        chk("R8 hc released", hc_rst, 1'b0);
        step(34);
        chk("R8 ifclk before", {if_clk_en, role_dev}, 2'b01);
        step(35);
        chk("R8 host mode", {if_clk_en, role_dev, phy_rst, done}, 4'b1010);
        step(36);
        chk("R9 done", {phy_rst, done, err}, 3'b010);
        chk("R10 busy start ignored", {div_sel, mult}, {3'd1, 7'h19});
        step(45);
        chk("R9 done holds", done, 1'b1);

        // R4 select mismatch
        sel_flip = 3'b001;
        kick(14'd1000, 2'd2, 2'd1);
        chk("R9 done cleared", done, 1'b0);
        step(4);
        chk("R4 err sel", {err, done, div_rst}, 3'b101);
        step(25);
        chk("R4 halted", {err, ctl_rst, hc_rst, div_rst}, 4'b1111);
        sel_flip = '0;

        // R4 enable reads 0
        en_kill = 1'b1;
        kick(14'd600, 2'd0, 2'd0);
        chk("R9 err cleared", err, 1'b0);
        step(4);
        chk("R4 err enable", {err, done, div_rst}, 3'b101);
        en_kill = 1'b0;

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [2:0] ed;
            logic [6:0] em;
            logic [5:0] ef;
            logic [13:0] vm;
            logic [1:0] vr, vs;
            {vm, vr, vs, ed, em, ef} = VEC[v];
            kick(vm, vr, vs);
            step(40);
            chk("R3 table div", div_sel, ed);
            chk("R6 table mult", mult, em);
            chk("R7 table fsel", fsel, ef);
            chk("R7 table src", ref_src, vs);
            chk("R9 table flags", {done, err, phy_rst}, 3'b100);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule